// File: doc/BRIEF.md
# Shared-prescaler timer tick generator

This block turns one peripheral clock into count-enable strobes for a five-channel timer. Two 8-bit prescalers divide the clock first. The lower prescaler feeds channels 0 and 1. The upper prescaler feeds channels 2, 3 and 4. Each channel then applies its own power-of-two division to the output of its prescaler. The result is one single-cycle enable pulse per channel. Each channel's timer counter advances on that pulse.

Software programs two configuration words through a simple write port. The prescale word holds both prescaler fields. The divide-select word holds a 4-bit code for each channel. A code names a power of two, offset by a build-time base. The base is 1 for a narrow-counter build, where the smallest division is 2, and 0 for a wide-counter build, where the smallest division is 1.

A channel's tick rate is the clock divided by (prescaler ratio × channel division). All channels on one prescaler share a single stage counter. Channels that use the same prescaler and the same code therefore tick in the same cycle.

Top module: `tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every tick output is low. Reset leaves both prescaler ratios at 1 and every divide-select code at 0.
- R2: A write with `cfg_sel`=0 loads prescaler A from `cfg_wdata[7:0]` (used by channels 0 and 1) and prescaler B from `cfg_wdata[15:8]` (used by channels 2 to 4). A write with `cfg_sel`=1 loads the code of channel c from `cfg_wdata[4c+3:4c]`.
- R3: A prescaler field value p gives a prescaler strobe once every p+1 clocks.
- R4: A new prescaler value is held until the current prescaler period ends. It governs only the periods that start after that end.
- R5: A code k gives a division of 2^(k+LOG2_BASE). A channel's tick period is (p+1)·2^(k+LOG2_BASE) clocks, and each tick comes one clock after the prescaler strobe that completes the division.
- R6: A code whose division would exceed 2^LOG2_MAX (16 by default) divides by 2^LOG2_MAX.
- R7: Each tick is a single-clock pulse. With LOG2_BASE ≥ 1, no channel ticks in two consecutive cycles.
- R8: Channels that share a prescaler and hold equal codes tick in exactly the same cycles.
- R9: A change to a divide-select code applies from the next clock. It does not restart the shared stage counter, so the other channels keep their phase.
- R10: Bits of a configuration word outside the defined fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: prescale word, 1: divide-select word |
| cfg_wdata | input | 32 | Configuration write data |
| tick_o | output | 5 | Per-channel single-cycle count enables |

## Verification
A wrong prescaler count or a badly timed reload shows up within one prescaler period. Every channel on that prescaler then ticks in the wrong cycle. A wrong stage-counter phase or a wrong code decode shows up within at most 2^LOG2_MAX prescaler periods, as a misplaced tick on the affected channel. Once two channels on the same prescaler hold equal codes, a phase split between them appears at the first tick.

The bench keeps a behavioural model that predicts all five outputs and compares them every clock. It therefore reports such a fault in the first cycle it reaches the ports. The bench drives prescaler changes in the middle of a period, saturating codes, and code changes while the divider is running.

// File: rtl/tick_pkg.sv
package tick_pkg;

   typedef enum logic {
      CFG_PRESCALE = 1'b0,
      CFG_DIVSEL   = 1'b1
   } cfg_sel_e;

   // Effective log2 division for a code: offset by the base, clamped at the limit.
   function automatic int unsigned eff_log2(input int unsigned code,
                                            input int unsigned base,
                                            input int unsigned lim);
      int unsigned s;
      s = code + base;
      return (s > lim) ? lim : s;
   endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int PRE_W = 8,
   parameter int STG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [PRE_W-1:0] load_val,
   output logic             strobe,
   output logic [STG_W-1:0] stage
);

   logic [PRE_W-1:0] shadow_q;
   logic [PRE_W-1:0] act_q;
   logic [PRE_W-1:0] cnt_q;
   logic [STG_W-1:0] stage_q;

   assign strobe = (cnt_q == act_q);
   assign stage  = stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (load_en) begin
         shadow_q <= load_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         cnt_q   <= '0;
         stage_q <= '0;
      end else if (strobe) begin
         act_q   <= shadow_q;
         cnt_q   <= '0;
         stage_q <= stage_q + 1'b1;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R3: the count never runs past the active terminal value
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= act_q);

   // R4: the active ratio changes only right after a terminal count
   p_reload_at_terminal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(strobe) |-> $stable(act_q));

   // R9: the shared stage counter moves only on a strobe
   p_stage_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(strobe) |-> $stable(stage_q));

endmodule

// File: rtl/tick_chan_div.sv
module tick_chan_div
   import tick_pkg::*;
#(
   parameter int SEL_W     = 4,
   parameter int STG_W     = 4,
   parameter int LOG2_BASE = 1,
   parameter int LOG2_MAX  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [STG_W-1:0] stage,
   input  logic [SEL_W-1:0] code,
   output logic             tick
);

   logic tick_q;
   logic hit;

   generate
      if (LOG2_MAX == 0) begin : g_nodiv
         assign hit = strobe;
      end else begin : g_div
         logic [STG_W-1:0] mask;
         int unsigned      l2;
         always_comb begin
            l2   = eff_log2(int'(code), LOG2_BASE, LOG2_MAX);
            mask = STG_W'((64'd1 << l2) - 64'd1);
         end
         assign hit = strobe && ((stage & mask) == mask);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= hit;
   end

   assign tick = tick_q;

   // R5: every tick follows a prescaler strobe by one clock
   p_tick_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> $past(strobe));

   generate
      if (LOG2_BASE > 0 && LOG2_MAX > 0) begin : g_pulse_chk
         // R7: never two ticks back to back when the minimum division is 2
         p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tick_q |=> !tick_q);
      end
   endgenerate

endmodule

// File: rtl/tick_gen.sv
module tick_gen
   import tick_pkg::*;
#(
   parameter int NUM_CH    = 5,
   parameter int SPLIT_CH  = 2,
   parameter int PRE_W     = 8,
   parameter int SEL_W     = 4,
   parameter int LOG2_BASE = 1,
   parameter int LOG2_MAX  = 4,
   parameter int WORD_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [NUM_CH-1:0] tick_o
);

   localparam int NUM_PRE = 2;
   localparam int STG_W   = (LOG2_MAX > 0) ? LOG2_MAX : 1;
   localparam int DIV_W   = NUM_CH * SEL_W;

   // elaboration-time parameter checks
   generate
      if (WORD_W < NUM_PRE * PRE_W) begin : g_bad_pre
         $error("tick_gen: WORD_W too narrow for prescale fields");
      end
      if (WORD_W < DIV_W) begin : g_bad_div
         $error("tick_gen: WORD_W too narrow for divide-select fields");
      end
      if (SPLIT_CH < 1 || SPLIT_CH >= NUM_CH) begin : g_bad_split
         $error("tick_gen: SPLIT_CH must leave channels on both prescalers");
      end
      if (LOG2_BASE > LOG2_MAX) begin : g_bad_log2
         $error("tick_gen: LOG2_BASE exceeds LOG2_MAX");
      end
   endgenerate

   cfg_sel_e         sel;
   logic             pre_wr;
   logic [DIV_W-1:0] div_q;
   logic [NUM_PRE-1:0] pre_strobe;
   logic [STG_W-1:0] pre_stage [NUM_PRE];

   assign sel    = cfg_sel_e'(cfg_sel);
   assign pre_wr = cfg_we && (sel == CFG_PRESCALE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (cfg_we && sel == CFG_DIVSEL) begin
         div_q <= cfg_wdata[DIV_W-1:0];
      end
   end

   generate
      for (genvar k = 0; k < NUM_PRE; k++) begin : g_pre
         tick_prescaler #(
            .PRE_W(PRE_W),
            .STG_W(STG_W)
         ) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (pre_wr),
            .load_val(cfg_wdata[k*PRE_W +: PRE_W]),
            .strobe  (pre_strobe[k]),
            .stage   (pre_stage[k])
         );
      end

      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int GRP = (c < SPLIT_CH) ? 0 : 1;
         tick_chan_div #(
            .SEL_W    (SEL_W),
            .STG_W    (STG_W),
            .LOG2_BASE(LOG2_BASE),
            .LOG2_MAX (LOG2_MAX)
         ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .strobe(pre_strobe[GRP]),
            .stage (pre_stage[GRP]),
            .code  (div_q[c*SEL_W +: SEL_W]),
            .tick  (tick_o[c])
         );

         if (c > 0 && c != SPLIT_CH) begin : g_align
            // R8: neighbours on one prescaler with equal settled codes tick together
            p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
               ($stable(div_q) && div_q[c*SEL_W +: SEL_W] == div_q[(c-1)*SEL_W +: SEL_W])
               |-> (tick_o[c] == tick_o[c-1]));
         end
      end
   endgenerate

endmodule

// File: tb/tick_gen_test.sv
`timescale 1ns/1ps
module tick_gen_test;

   localparam int NCH  = 5;
   localparam int BASE = 1;
   localparam int LMAX = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [4:0]  tick_o;

   always #2.5 clk = ~clk;

   tick_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .tick_o(tick_o)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   string tag = "R1";
   bit    chk_align = 1'b0;
   bit    done = 1'b0;

   // behavioural reference model
   int m_shadow [2];
   int m_act    [2];
   int m_cnt    [2];
   int m_stage  [2];
   int m_code   [NCH];
   bit m_exp    [NCH];
   bit prev_tick [NCH];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_shadow[k] = 0; m_act[k] = 0; m_cnt[k] = 0; m_stage[k] = 0;
         end
         for (int c = 0; c < NCH; c++) begin
            m_code[c] = 0; m_exp[c] = 1'b0;
         end
      end else begin
         bit st [2];
         for (int k = 0; k < 2; k++) st[k] = (m_cnt[k] == m_act[k]);
         for (int c = 0; c < NCH; c++) begin
            int g, l, per;
            g = (c < 2) ? 0 : 1;
            l = m_code[c] + BASE;
            if (l > LMAX) l = LMAX;
            per = 1 << l;
            m_exp[c] = st[g] && ((m_stage[g] % per) == per - 1);
         end
         for (int k = 0; k < 2; k++) begin
            if (st[k]) begin
               m_act[k] = m_shadow[k];
               m_cnt[k] = 0;
               m_stage[k] = (m_stage[k] + 1) % (1 << LMAX);
            end else begin
               m_cnt[k] = m_cnt[k] + 1;
            end
         end
         if (cfg_we && !cfg_sel) begin
            m_shadow[0] = int'(cfg_wdata[7:0]);
            m_shadow[1] = int'(cfg_wdata[15:8]);
         end
         if (cfg_we && cfg_sel) begin
            for (int c = 0; c < NCH; c++) m_code[c] = int'(cfg_wdata[4*c +: 4]);
         end
      end
   end

   // comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [4:0] exp_v;
         for (int c = 0; c < NCH; c++) exp_v[c] = m_exp[c];
         n_chk++;
         if (tick_o !== exp_v) begin
            n_bad++;
            $display("FAIL %s: tick_o=%b expected %b at %0t", tag, tick_o, exp_v, $time);
         end
         // R7: single-cycle pulses
         n_chk++;
         for (int c = 0; c < NCH; c++) begin
            if (tick_o[c] === 1'b1 && prev_tick[c]) begin
               n_bad++;
               $display("FAIL R7: ch%0d tick=1 twice, expected a single-cycle pulse", c);
            end
         end
         // R8: shared prescaler, equal code
         if (chk_align) begin
            n_chk++;
            if (tick_o[0] !== tick_o[1] || tick_o[2] !== tick_o[3]) begin
               n_bad++;
               $display("FAIL R8: tick_o=%b expected bit0==bit1 and bit2==bit3", tick_o);
            end
         end
         for (int c = 0; c < NCH; c++) prev_tick[c] = (tick_o[c] === 1'b1);
      end
   end

   task automatic wr(input bit s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0; cfg_wdata = 32'hDEAD_BEEF;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) prev_tick[c] = 1'b0;
      // R1: outputs low during reset
      run(3);
      n_chk++;
      if (tick_o !== 5'b0) begin
         n_bad++;
         $display("FAIL R1: tick_o=%b expected 00000 in reset", tick_o);
      end
      @(negedge clk); rst_n = 1'b1;
      // R1/R5: defaults, ratio 1 and /2
      tag = "R1/R5 defaults"; run(40);
      // R2/R10/R3: prescalers with junk in upper bits
      tag = "R2/R10/R3 prescale"; wr(1'b0, 32'hABCD_0402); run(120);
      // R5/R8: codes ch0=0 ch1=0 ch2=1 ch3=1 ch4=2 with junk above
      tag = "R5/R8 codes"; wr(1'b1, 32'hFFF2_1100); chk_align = 1'b1; run(400);
      // R6: saturating codes ch2=4 ch3=4 ch4=15, ch0=ch1=3
      tag = "R6 saturate"; wr(1'b1, 32'h000F_4433); run(700);
      // R4: prescaler change mid period
      tag = "R4 reload"; run(3); wr(1'b0, 32'h0000_0507); run(500);
      tag = "R4 reload back"; wr(1'b0, 32'h0000_0001); run(200);
      // R9: code change while running
      chk_align = 1'b0;
      tag = "R9 code change"; wr(1'b1, 32'h0000_2301); run(7); wr(1'b1, 32'h0000_0210); run(200);
      tag = "R10 zero prescale"; wr(1'b0, 32'hFFFF_0000); run(100);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: run still active, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule